// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers level-held interrupt requests from a set of device interfaces and decides which single one, if any, is handed to the processor. Every device has its own configured priority number and vector. Lower numbers are more urgent. The controller evaluates the pending requests only when the processor signals that an instruction has finished. At that point it picks the most urgent pending request. It presents that request only if its number is strictly below the processor's current priority level.

Once a request is presented, the controller raises a registered interrupt line. It also drives the chosen device's vector and index, so the service routine can be located without polling. These outputs stay frozen until the processor acknowledges that device, or until the device withdraws its request. A request that is withdrawn before the boundary is never remembered.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0 and `src_o` is 0.
- R2: A request is never presented unless `boundary_i` was high at the sampling clock edge; without a boundary, `irq_o` stays 0 however long a request is held.
- R3: At a boundary with `irq_o` low, the eligible request with the numerically smallest priority is presented: on the next cycle `irq_o` is 1, `src_o` is its index and `vec_o` is its configured vector (device i's priority is `prio_cfg_i[i*PRIO_W +: PRIO_W]`, its vector is `vec_cfg_i[i*VEC_W +: VEC_W]`).
- R4: Among eligible requests with equal priority numbers, the lowest device index wins.
- R5: A request is eligible only if its priority number is strictly smaller than `cur_level_i`; equal or larger numbers are not presented.
- R6: With `cur_level_i` equal to 0, no request is ever presented.
- R7: Requests are not latched: a request raised and withdrawn before a boundary has no effect at that boundary.
- R8: While `irq_o` is 1, `src_o` and `vec_o` hold their values across further boundaries and across changes on other request lines, until an acknowledge or withdrawal.
- R9: `ack_i` high with `ack_id_i` equal to `src_o` clears `irq_o`, `src_o` and `vec_o` on the next cycle; an acknowledge naming another index is ignored.
- R10: If the presented device drops its request line while `irq_o` is 1, `irq_o` is cleared on the next cycle.
- R11: After a clear, the next boundary selects again from the requests pending at that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_SRC | Level-held request per device |
| prio_cfg_i | input | N_SRC*PRIO_W | Packed priority number per device |
| vec_cfg_i | input | N_SRC*VEC_W | Packed vector per device |
| cur_level_i | input | PRIO_W | Processor's current priority level |
| boundary_i | input | 1 | End-of-instruction strobe |
| ack_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | IDW | Index of the device being acknowledged |
| irq_o | output | 1 | Interrupt request toward the processor |
| vec_o | output | VEC_W | Vector of the presented device |
| src_o | output | IDW | Index of the presented device |

## Verification
A wrong selection in the arbiter shows up as a wrong `src_o` or `vec_o` one cycle after the boundary that sampled it. A wrong eligibility test shows up on `irq_o` in that same cycle. A stuck or stale holding register is exposed at the following boundary or acknowledge. It then either fails to release within one cycle of a matching acknowledge or withdrawal, or it changes while it should hold. The directed scenarios place each of these events on a known cycle so that any deviation appears within one or two cycles.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8,
  localparam int IDW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          req_i,
  input  logic [N_SRC*PRIO_W-1:0]   prio_cfg_i,
  input  logic [N_SRC*VEC_W-1:0]    vec_cfg_i,
  input  logic [PRIO_W-1:0]         cur_level_i,
  input  logic                      boundary_i,
  input  logic                      ack_i,
  input  logic [IDW-1:0]            ack_id_i,
  output logic                      irq_o,
  output logic [VEC_W-1:0]          vec_o,
  output logic [IDW-1:0]            src_o
);

  logic              found;
  logic [IDW-1:0]    best_id;
  logic [PRIO_W-1:0] best_p;
  logic [VEC_W-1:0]  best_vec;

  always_comb begin
    found    = 1'b0;
    best_id  = '0;
    best_p   = '0;
    best_vec = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (prio_cfg_i[i*PRIO_W +: PRIO_W] < cur_level_i) &&
          (!found || (prio_cfg_i[i*PRIO_W +: PRIO_W] < best_p))) begin
        found    = 1'b1;
        best_id  = IDW'(i);
        best_p   = prio_cfg_i[i*PRIO_W +: PRIO_W];
        best_vec = vec_cfg_i[i*VEC_W +: VEC_W];
      end
    end
  end

  wire ack_hit = ack_i && (ack_id_i == src_o);
  wire dropped = !req_i[src_o];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      vec_o <= '0;
      src_o <= '0;
    end else if (irq_o) begin
      if (ack_hit || dropped) begin
        irq_o <= 1'b0;
        vec_o <= '0;
        src_o <= '0;
      end
    end else if (boundary_i && found) begin
      irq_o <= 1'b1;
      vec_o <= best_vec;
      src_o <= best_id;
    end
  end

  // R2
  rise_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(boundary_i));

  // R6
  masked_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(cur_level_i) != '0));

  // R8
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ack_hit && !dropped) |=> (irq_o && $stable(vec_o) && $stable(src_o)));

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_hit) |=> !irq_o);

  // R10
  drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && dropped) |=> !irq_o);

endmodule

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
  localparam int N = 8, PW = 4, VW = 8, IW = 3;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req = '0;
  logic [N*PW-1:0] prio;
  logic [N*VW-1:0] vecs;
  logic [PW-1:0] level = 4'd15;
  logic bnd = 0, ack = 0;
  logic [IW-1:0] ack_id = '0;
  logic irq;
  logic [VW-1:0] vec;
  logic [IW-1:0] src;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl #(.N_SRC(N), .PRIO_W(PW), .VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_cfg_i(prio), .vec_cfg_i(vecs),
    .cur_level_i(level), .boundary_i(bnd), .ack_i(ack), .ack_id_i(ack_id),
    .irq_o(irq), .vec_o(vec), .src_o(src));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input logic i, input logic [IW-1:0] s, input logic [VW-1:0] v);
    chk({tag, " irq"}, 32'(irq), 32'(i));
    chk({tag, " src"}, 32'(src), 32'(s));
    chk({tag, " vec"}, 32'(vec), 32'(v));
  endtask

  task automatic strobe();
    bnd = 1; @(negedge clk); bnd = 0;
  endtask

  task automatic give_ack(input logic [IW-1:0] id);
    ack = 1; ack_id = id; @(negedge clk); ack = 0;
  endtask

  function automatic logic [VW-1:0] vv(input int i);
    return VW'(8'hA0 + i);
  endfunction

  task automatic t_reset();
    expect_out("R1 reset", 0, 0, 0);
  endtask

  task automatic t_no_boundary();
    req = 8'b0000_0010;
    repeat (4) @(negedge clk);
    chk("R2 no boundary", 32'(irq), 0);
    req = '0; @(negedge clk);
  endtask

  task automatic t_pick();
    req = 8'b0100_0011;
    strobe();
    expect_out("R3 most urgent", 1, 1, vv(1));
    give_ack(1);
    expect_out("R9 ack clears", 0, 0, 0);
    req = '0; @(negedge clk);
  endtask

  task automatic t_tie_drop();
    req = 8'b0000_1100;
    strobe();
    expect_out("R4 tie low index", 1, 2, vv(2));
    req = 8'b0000_1000; @(negedge clk);
    chk("R10 drop clears", 32'(irq), 0);
    strobe();
    expect_out("R11 reselect", 1, 3, vv(3));
    give_ack(3);
    req = '0; @(negedge clk);
  endtask

  task automatic t_strict();
    level = 4'd5; req = 8'b0000_0010;
    strobe();
    chk("R5 equal not taken", 32'(irq), 0);
    level = 4'd6;
    strobe();
    expect_out("R5 below taken", 1, 1, vv(1));
    give_ack(1);
    req = '0; level = 4'd15; @(negedge clk);
  endtask

  task automatic t_mask();
    level = 4'd0; req = 8'hFF;
    strobe(); @(negedge clk);
    chk("R6 level zero masks", 32'(irq), 0);
    req = '0; level = 4'd15; @(negedge clk);
  endtask

  task automatic t_withdraw();
    req = 8'b0010_0000; @(negedge clk);
    req = '0; @(negedge clk);
    strobe();
    chk("R7 withdrawn not latched", 32'(irq), 0);
  endtask

  task automatic t_hold();
    req = 8'b0001_0000;
    strobe();
    expect_out("R3 single", 1, 4, vv(4));
    req = 8'b0011_0000;
    strobe();
    expect_out("R8 hold over boundary", 1, 4, vv(4));
    give_ack(5);
    expect_out("R9 wrong id ignored", 1, 4, vv(4));
    give_ack(4);
    chk("R9 ack", 32'(irq), 0);
    req = 8'b0010_0000;
    strobe();
    expect_out("R11 next pending", 1, 5, vv(5));
    give_ack(5);
    req = '0; @(negedge clk);
  endtask

  initial begin
    // priorities 9,5,3,3,12,1,7,14; vectors A0+i
    prio = {4'd14, 4'd7, 4'd1, 4'd12, 4'd3, 4'd3, 4'd5, 4'd9};
    for (int i = 0; i < N; i++) vecs[i*VW +: VW] = vv(i);
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset();
    t_no_boundary();
    t_pick();
    t_tie_drop();
    t_strict();
    t_mask();
    t_withdraw();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule